// File: doc/BRIEF.md
# Power-Down and CPU Clock Controller

This block decides, cycle by cycle, whether the CPU of a small controller may advance and whether the main oscillator must run. It produces a one-cycle CPU clock enable every 4, 8 or 64 oscillator cycles, chosen by a software-written select, and a level-type peripheral clock enable that stays high while the oscillator runs. There are four states: run, idle, stop and a stabilisation wait.

An idle request stops only the CPU enable. An enabled interrupt request brings the block out of idle on the next cycle. A stop request also turns the oscillator off. Leaving stop always passes through the stabilisation wait, during which the oscillator runs but the CPU enable stays low. The length of that wait depends on how the block was woken. After reset it lasts `2**RST_WAIT_LOG2` cycles (2^17 by default). After an interrupt it lasts `2**(IRQ_WAIT_LOG2_MIN + wake_sel_i)` cycles. The select `wake_sel_i` is taken from the interval setting of the basic timer.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pstate_o` is 3 (wait), `osc_run_o` and `periph_ce_o` are 1, and `cpu_ce_o` is 0. After release, the wait state lasts exactly `2**RST_WAIT_LOG2` cycles, counting the release cycle, and then `pstate_o` becomes 0 (run).
- R2: In run, `cpu_ce_o` is a single-cycle pulse repeating every D cycles. D is set by the divider select register: code 00 gives 64, code 01 gives 8 and code 11 gives 4. Reset sets code 00.
- R3: A write (`div_wr_i` high) with code 10 is ignored. The pulse period stays what it was before the write.
- R4: An idle request in run with no interrupt pending moves the block to state 1 (idle). In idle, `cpu_ce_o` is 0 and `osc_run_o` and `periph_ce_o` stay 1.
- R5: In idle, a pending interrupt returns the block to run on the next cycle, with no wait.
- R6: A stop request in run with no interrupt pending moves the block to state 2 (stop). In stop, `osc_run_o`, `periph_ce_o` and `cpu_ce_o` are all 0.
- R7: In stop, a pending interrupt moves the block to state 3 (wait). The wait lasts exactly `2**(IRQ_WAIT_LOG2_MIN + wake_sel_i)` cycles, with `wake_sel_i` sampled on the waking cycle. The oscillator runs and `cpu_ce_o` stays 0 throughout; the block then returns to run.
- R8: In run, a stop or idle request is ignored while `irq_pend_i` is high. If both requests arrive together, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | Request to enter idle |
| stop_req_i | input | 1 | Request to enter stop |
| irq_pend_i | input | 1 | An enabled interrupt request is pending |
| wake_sel_i | input | 2 | Interval setting that selects the wait after an interrupt wake |
| div_wr_i | input | 1 | Write strobe for the divider select |
| div_sel_i | input | 2 | Divider code to write |
| cpu_ce_o | output | 1 | CPU clock enable pulse |
| periph_ce_o | output | 1 | Peripheral clock enable |
| osc_run_o | output | 1 | Main oscillator enable |
| pstate_o | output | 2 | State: 0 run, 1 idle, 2 stop, 3 wait |

## Verification
The bench builds the block with `RST_WAIT_LOG2` set to 6 and `IRQ_WAIT_LOG2_MIN` set to 3. This makes the reset wait 64 cycles and the interrupt waits 8, 16, 32 and 64 cycles. Every wait length, including the largest interrupt window, can then be counted to the exact cycle within a short run. The counting logic is the same as at the default lengths, which differ only in counter width.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_IDLE = 2'd1,
    PS_STOP = 2'd2,
    PS_WAIT = 2'd3
  } pcc_state_e;

  localparam logic [1:0] DIVC_SLOW = 2'b00;
  localparam logic [1:0] DIVC_MID  = 2'b01;
  localparam logic [1:0] DIVC_BAD  = 2'b10;
  localparam logic [1:0] DIVC_FAST = 2'b11;
endpackage

// File: rtl/pcc_clk_div.sv
module pcc_clk_div #(
  parameter int DIV_SLOW = 64,
  parameter int DIV_MID  = 8,
  parameter int DIV_FAST = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wr_i,
  input  logic [1:0] sel_i,
  output logic       ce_o
);
  import pcc_pkg::*;
  localparam int DIV_W = $clog2(DIV_SLOW);

  logic [1:0]       sel_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] top_v;
  logic             wr_ok;

  assign wr_ok = wr_i && (sel_i != DIVC_BAD);

  always_comb begin
    case (sel_q)
      DIVC_FAST: top_v = DIV_W'(DIV_FAST - 1);
      DIVC_MID:  top_v = DIV_W'(DIV_MID - 1);
      default:   top_v = DIV_W'(DIV_SLOW - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= DIVC_SLOW;
    end else if (wr_ok) begin
      sel_q <= sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || wr_ok || cnt_q == top_v) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ce_o = en_i && (cnt_q == top_v);

  // R2: the enable is never high two cycles in a row
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |=> !ce_o);
  // R3: a write of the reserved code leaves the select unchanged
  a_r3_bad_code_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == DIVC_BAD) |=> $stable(sel_q));
endmodule

// File: rtl/pcc_wait_timer.sv
module pcc_wait_timer #(
  parameter int CNT_W   = 18,
  parameter int RST_LEN = 131072
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(RST_LEN);
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == lim_q - 1'b1);

  // R1, R7: the count never passes its limit while waiting
  a_r7_cnt_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim_q));
endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_req_i,
  input  logic              stop_req_i,
  input  logic              irq_i,
  input  logic              done_i,
  output pcc_pkg::pcc_state_e state_o,
  output logic              load_o
);
  import pcc_pkg::*;
  pcc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_RUN: begin
        if (!irq_i) begin
          if (stop_req_i)      st_d = PS_STOP;
          else if (idle_req_i) st_d = PS_IDLE;
        end
      end
      PS_IDLE: if (irq_i)  st_d = PS_RUN;
      PS_STOP: if (irq_i)  st_d = PS_WAIT;
      PS_WAIT: if (done_i) st_d = PS_RUN;
      default: st_d = PS_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PS_WAIT;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign load_o  = (st_q == PS_STOP) && irq_i;

  // R5: idle ends on the cycle after an interrupt
  a_r5_idle_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_IDLE && irq_i) |=> st_q == PS_RUN);
  // R8: a pending interrupt keeps the block running
  a_r8_irq_holds_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_RUN && irq_i) |=> st_q == PS_RUN);
  // R7: stop always goes through the wait
  a_r7_stop_to_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_STOP && irq_i) |=> st_q == PS_WAIT);
  // R1, R7: the wait is not left before the timer finishes
  a_r1_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_WAIT && !done_i) |=> st_q == PS_WAIT);
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl #(
  parameter int RST_WAIT_LOG2     = 17,
  parameter int IRQ_WAIT_LOG2_MIN = 10,
  parameter int DIV_SLOW          = 64,
  parameter int DIV_MID           = 8,
  parameter int DIV_FAST          = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_req_i,
  input  logic       stop_req_i,
  input  logic       irq_pend_i,
  input  logic [1:0] wake_sel_i,
  input  logic       div_wr_i,
  input  logic [1:0] div_sel_i,
  output logic       cpu_ce_o,
  output logic       periph_ce_o,
  output logic       osc_run_o,
  output logic [1:0] pstate_o
);
  import pcc_pkg::*;
  localparam int NUM_WAKE = 4;
  localparam int MAX_LOG2 = (RST_WAIT_LOG2 > IRQ_WAIT_LOG2_MIN + NUM_WAKE - 1)
                          ? RST_WAIT_LOG2 : IRQ_WAIT_LOG2_MIN + NUM_WAKE - 1;
  localparam int CNT_W    = MAX_LOG2 + 1;

  pcc_state_e       state;
  logic             load, done;
  logic [CNT_W-1:0] lim_tbl [NUM_WAKE];

  for (genvar k = 0; k < NUM_WAKE; k++) begin : g_wake_lim
    assign lim_tbl[k] = CNT_W'(1) << (IRQ_WAIT_LOG2_MIN + k);
  end

  pcc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_req_i (idle_req_i),
    .stop_req_i (stop_req_i),
    .irq_i      (irq_pend_i),
    .done_i     (done),
    .state_o    (state),
    .load_o     (load)
  );

  pcc_wait_timer #(
    .CNT_W   (CNT_W),
    .RST_LEN (1 << RST_WAIT_LOG2)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .limit_i (lim_tbl[wake_sel_i]),
    .run_i   (state == PS_WAIT),
    .done_o  (done)
  );

  pcc_clk_div #(
    .DIV_SLOW (DIV_SLOW),
    .DIV_MID  (DIV_MID),
    .DIV_FAST (DIV_FAST)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state == PS_RUN),
    .wr_i   (div_wr_i),
    .sel_i  (div_sel_i),
    .ce_o   (cpu_ce_o)
  );

  assign osc_run_o   = (state != PS_STOP);
  assign periph_ce_o = (state != PS_STOP);
  assign pstate_o    = state;

  // R6: the oscillator is off on the cycle after an accepted stop request
  a_r6_stop_kills_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PS_RUN && stop_req_i && !irq_pend_i) |=> !osc_run_o);
  // R4: no CPU pulse on the cycle after entering idle
  a_r4_idle_no_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PS_RUN && idle_req_i && !stop_req_i && !irq_pend_i) |=> (!cpu_ce_o && osc_run_o));
endmodule

// File: tb/test_pwr_clk_ctrl.sv
module test_pwr_clk_ctrl;
  localparam int RLOG = 6;
  localparam int IMIN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 0, stop_req = 0, irq = 0, div_wr = 0;
  logic [1:0] wsel = 0, dsel = 0;
  logic cpu_ce, periph_ce, osc_run;
  logic [1:0] pstate;

  int errors = 0, checks = 0, cycles = 0;
  int ms, mrem, msel, mdc;
  bit mvalid = 0;

  always #10 clk = ~clk;

  pwr_clk_ctrl #(.RST_WAIT_LOG2(RLOG), .IRQ_WAIT_LOG2_MIN(IMIN)) i_pwr_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .idle_req_i(idle_req), .stop_req_i(stop_req),
    .irq_pend_i(irq), .wake_sel_i(wsel), .div_wr_i(div_wr), .div_sel_i(dsel),
    .cpu_ce_o(cpu_ce), .periph_ce_o(periph_ce), .osc_run_o(osc_run), .pstate_o(pstate));

  function automatic int period(int s);
    return (s == 3) ? 4 : (s == 1) ? 8 : 64;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ms = 3; mrem = 1 << RLOG; msel = 0; mdc = 0; mvalid = 1;
    end else begin
      if (ms != 0) mdc = 0;
      else if (div_wr && dsel != 2) mdc = 0;
      else if (mdc == period(msel) - 1) mdc = 0;
      else mdc++;
      if (div_wr && dsel != 2) msel = dsel;
      case (ms)
        0: if (!irq) begin if (stop_req) ms = 2; else if (idle_req) ms = 1; end
        1: if (irq) ms = 0;
        2: if (irq) begin ms = 3; mrem = 1 << (IMIN + wsel); end
        default: if (mrem == 1) ms = 0; else mrem--;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && mvalid) begin
      chk("R1/R4/R6/R7 state", pstate, ms);
      chk("R4/R6 osc_run", osc_run, ms != 2);
      chk("R4/R6 periph_ce", periph_ce, ms != 2);
      chk("R2/R3 cpu_ce", cpu_ce, (ms == 0 && mdc == period(msel) - 1));
    end
  end

  always @(posedge clk) if (cycles >= 200000) begin
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<200000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_gap(string tag, int exp);
    int n;
    while (!cpu_ce) step(1);
    n = 0;
    do begin step(1); n++; end while (!cpu_ce);
    chk(tag, n, exp);
  endtask

  task automatic measure_wait(string tag, int exp);
    int n = 0;
    while (pstate == 3) begin n++; step(1); end
    chk(tag, n, exp);
  endtask

  initial begin
    step(2);
    chk("R1 reset state", pstate, 3);
    chk("R1 reset osc", osc_run, 1);
    chk("R1 reset periph", periph_ce, 1);
    chk("R1 reset cpu_ce", cpu_ce, 0);
    rst_n = 1;
    measure_wait("R1 reset wait length", 1 << RLOG);
    measure_gap("R2 default /64", 64);
    div_wr = 1; dsel = 2'b01; step(1); div_wr = 0;
    measure_gap("R2 code 01 /8", 8);
    div_wr = 1; dsel = 2'b11; step(1); div_wr = 0;
    measure_gap("R2 code 11 /4", 4);
    div_wr = 1; dsel = 2'b01; step(1); div_wr = 0;
    div_wr = 1; dsel = 2'b10; step(1); div_wr = 0;
    measure_gap("R3 code 10 ignored", 8);
    measure_gap("R3 period kept", 8);
    // R4 idle
    idle_req = 1; step(1); idle_req = 0;
    chk("R4 idle state", pstate, 1);
    step(5);
    chk("R4 idle cpu_ce", cpu_ce, 0);
    chk("R4 idle osc", osc_run, 1);
    irq = 1; step(1);
    chk("R5 idle wake", pstate, 0);
    // R8 requests ignored while irq pending
    stop_req = 1; idle_req = 1; step(1);
    chk("R8 stop ignored", pstate, 0);
    irq = 0; step(1); stop_req = 0; idle_req = 0;
    chk("R8 stop wins", pstate, 2);
    chk("R6 stop osc", osc_run, 0);
    chk("R6 stop periph", periph_ce, 0);
    for (int s = 0; s < 4; s++) begin
      if (pstate != 2) begin stop_req = 1; step(1); stop_req = 0; end
      step(3);
      chk("R6 still stopped", pstate, 2);
      wsel = 2'(s); irq = 1; step(1); irq = 0; wsel = 0;
      measure_wait("R7 irq wait length", 1 << (IMIN + s));
      chk("R7 back to run", pstate, 0);
    end
    // R1 reset while stopped
    stop_req = 1; step(1); stop_req = 0;
    rst_n = 0; step(2);
    chk("R1 reset from stop", pstate, 3);
    rst_n = 1;
    measure_wait("R1 reset wait after stop", 1 << RLOG);
    measure_gap("R2 reset restores /64", 64);
    step(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule